// File: doc/BRIEF.md
# Open-Drain Parallel I/O Port

This block gives a serial codec interface two general-purpose pins that behave as open-drain lines. Each pin has a drive latch. A latch bit of 0 pulls the pin to ground. A latch bit of 1 lets go of the pin, so an external resistor or another device sets its level. The block samples the pin levels through a synchroniser and presents them in a status register. The serial shift engine sits beside this block, reads that register and shifts it out.

The port works in one of two interface modes, chosen by `mode_i`.

- **Control mode (`mode_i` = 0):** the pins are read-only. The engine's bit clock marks the sample point, and the fresh level is visible within the same frame. Writes are discarded.
- **Data mode (`mode_i` = 1):** the engine writes new latch values through the data-register port. All timing is counted in master-clock periods from the frame-sync rising edge. A pin is sampled eight and a half periods into the frame, on a falling master-clock edge. That sample is reported only when the following frame begins. A write reaches the pins eleven periods into the frame.

The engine supplies frame sync and bit clock as levels that are synchronous to the master clock `clk`. The block finds their rising edges itself.

Top module: `odpio_port`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, both latches are set to 1, so `pin_oe_o` = 2'b00 and `status_o` = 8'h03 from the next edge on.
- R2: Bit n of `pin_oe_o` is 1 (pin pulled low) exactly when latch bit n is 0. A latch bit of 1 leaves the pin undriven, so it can serve as an input.
- R3: In data mode, a value on `wr_data_i` presented with `wr_en_i` high reaches the latches on the 11th rising `clk` edge after the edge that sees `fsync_i` rise. `pin_oe_o` keeps its old value before that edge. If several writes arrive before that edge, the last one wins.
- R4: In data mode, the pin level is captured on the falling `clk` edge between the 8th and 9th rising edges after the frame-start edge. A pin change that reaches the synchroniser output after that falling edge is not captured in this frame.
- R5: In data mode, the captured value appears on `status_o` at the frame-start edge of the following frame, not earlier.
- R6: In control mode, `status_o` takes the synchronised pin level at the first rising `clk` edge that sees `bclk_i` rise after a frame start. Later bit-clock rises in the same frame leave it unchanged.
- R7: In control mode, `wr_en_i` is ignored. Neither the drive latches nor the pending write value change, so a later data-mode frame applies the value last written in data mode.
- R8: The pin level reaches the sample point through a two-stage synchroniser. The reported level is the one on `pin_i` at the rising edge two edges before the sample point.
- R9: Pin bit n of `status_o` is at bit position n (bits [1:0]). Bits [7:2] of `status_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; the data-mode timing counts its periods |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = control mode, 1 = data mode |
| fsync_i | input | 1 | Frame sync level, synchronous to `clk` |
| bclk_i | input | 1 | Serial bit clock level, synchronous to `clk` |
| wr_en_i | input | 1 | Data-register write strobe from the serial engine |
| wr_data_i | input | 2 | New latch values (data register bits [1:0]) |
| pin_i | input | 2 | Levels observed on the two pins |
| pin_oe_o | output | 2 | 1 = pull the pin low, 0 = release it |
| status_o | output | 8 | Sampled pin levels in bits [1:0], upper bits 0 |

## Verification
The assertions check several rules on every cycle:

- the reset values;
- that `pin_oe_o` never moves except on a data-mode apply strobe, and never moves at all in control mode;
- that `status_o` holds between update points;
- that a control-mode sample equals the pin level from three edges earlier.

The exact cycle positions need the bench's scenarios. These include the 11-edge write point, the half-cycle read point with pin changes one edge either side of it, and the one-frame read-back delay. The same applies to the last-write-wins rule and to the pending value surviving a control-mode write, because those show only at the pins of a later frame.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic {
    MODE_CTRL = 1'b0,
    MODE_DATA = 1'b1
  } pio_mode_e;
endpackage

// File: rtl/pio_sync.sv
// Multi-stage level synchroniser for asynchronous pin inputs.
module pio_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg_q[s] <= RST_VAL;
        else     stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg_q[s] <= RST_VAL;
        else     stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pio_frame_timer.sv
// Edge detection on frame sync and bit clock, plus the in-frame
// master-clock position counter that produces read and write points.
module pio_frame_timer #(
  parameter int RD_DELAY = 8,   // whole periods before the half-cycle read point
  parameter int WR_DELAY = 11   // periods from frame start to the write point
) (
  input  logic clk,
  input  logic rst,
  input  logic fsync_i,
  input  logic bclk_i,
  output logic frame_start_o,
  output logic bclk_first_o,
  output logic wr_stb_o,
  output logic rd_win_o
);
  localparam int CNT_MAX = WR_DELAY + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             fs_d_q;
  logic             bc_d_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bclk_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_d_q <= 1'b0;
      bc_d_q <= 1'b0;
    end else begin
      fs_d_q <= fsync_i;
      bc_d_q <= bclk_i;
    end
  end

  assign frame_start_o = fsync_i & ~fs_d_q;
  assign bclk_rise     = bclk_i & ~bc_d_q;
  assign bclk_first_o  = bclk_rise & armed_q;

  // Position in frame: 1 after the frame-start edge, k+1 after k more edges.
  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (frame_start_o)
      cnt_q <= CNT_W'(1);
    else if (cnt_q != '0 && cnt_q != CNT_W'(CNT_MAX))
      cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                armed_q <= 1'b0;
    else if (frame_start_o) armed_q <= 1'b1;
    else if (bclk_rise)     armed_q <= 1'b0;
  end

  assign wr_stb_o = (cnt_q == CNT_W'(WR_DELAY));
  assign rd_win_o = (cnt_q == CNT_W'(RD_DELAY + 1));

  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o)
    else $error("write point lasted more than one cycle");
endmodule

// File: rtl/pio_write_latch.sv
// Pending write register and pin drive latches (stored as drive enables).
module pio_write_latch #(
  parameter int NPINS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_data_i,
  input  logic             wr_en_i,
  input  logic [NPINS-1:0] wr_data_i,
  input  logic             apply_i,
  output logic [NPINS-1:0] drive_o
);
  logic [NPINS-1:0] pend_q;
  logic [NPINS-1:0] drive_q;
  logic             take_wr;
  logic [NPINS-1:0] next_latch;

  assign take_wr    = wr_en_i & mode_data_i;
  assign next_latch = take_wr ? wr_data_i : pend_q;

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= '1;
    else if (take_wr) pend_q <= wr_data_i;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)
        drive_q[p] <= 1'b0;
      else if (apply_i && mode_data_i)
        drive_q[p] <= ~next_latch[p];
    end
  end

  assign drive_o = drive_q;
endmodule

// File: rtl/pio_read_path.sv
// Half-cycle data-mode capture and the mode-dependent status register.
module pio_read_path #(
  parameter int NPINS = 2,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_data_i,
  input  logic [NPINS-1:0] pin_sync_i,
  input  logic             frame_start_i,
  input  logic             bclk_first_i,
  input  logic             rd_win_i,
  output logic [REG_W-1:0] status_o
);
  localparam int PAD = REG_W - NPINS;

  logic [NPINS-1:0] cap_q;
  logic [NPINS-1:0] st_q;

  // Falling-edge capture gives the half-period sample point.
  always_ff @(negedge clk) begin
    if (rst)
      cap_q <= '1;
    else if (mode_data_i && rd_win_i)
      cap_q <= pin_sync_i;
  end

  always_ff @(posedge clk) begin
    if (rst)
      st_q <= '1;
    else if (mode_data_i && frame_start_i)
      st_q <= cap_q;
    else if (!mode_data_i && bclk_first_i)
      st_q <= pin_sync_i;
  end

  assign status_o = {{PAD{1'b0}}, st_q};

  // R5 R6
  st_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(mode_data_i && frame_start_i) && !(!mode_data_i && bclk_first_i))
      |=> $stable(status_o))
    else $error("status changed outside an update point");
endmodule

// File: rtl/odpio_port.sv
module odpio_port #(
  parameter int NPINS       = 2,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RD_DELAY    = 8,
  parameter int WR_DELAY    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  logic             fsync_i,
  input  logic             bclk_i,
  input  logic             wr_en_i,
  input  logic [NPINS-1:0] wr_data_i,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_oe_o,
  output logic [REG_W-1:0] status_o
);
  import pio_pkg::*;

  localparam logic [REG_W-1:0] RST_STATUS = {{(REG_W-NPINS){1'b0}}, {NPINS{1'b1}}};
  localparam int               AGE_MAX    = 15;

  pio_mode_e        mode_e;
  logic             mode_data;
  logic [NPINS-1:0] pin_sync;
  logic             frame_start;
  logic             bclk_first;
  logic             wr_stb;
  logic             rd_win;

  assign mode_e    = pio_mode_e'(mode_i);
  assign mode_data = (mode_e == MODE_DATA);

  pio_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL({NPINS{1'b1}})) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_sync)
  );

  pio_frame_timer #(.RD_DELAY(RD_DELAY), .WR_DELAY(WR_DELAY)) timer_i (
    .clk           (clk),
    .rst           (rst),
    .fsync_i       (fsync_i),
    .bclk_i        (bclk_i),
    .frame_start_o (frame_start),
    .bclk_first_o  (bclk_first),
    .wr_stb_o      (wr_stb),
    .rd_win_o      (rd_win)
  );

  pio_write_latch #(.NPINS(NPINS)) wlatch_i (
    .clk         (clk),
    .rst         (rst),
    .mode_data_i (mode_data),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .apply_i     (wr_stb),
    .drive_o     (pin_oe_o)
  );

  pio_read_path #(.NPINS(NPINS), .REG_W(REG_W)) rpath_i (
    .clk           (clk),
    .rst           (rst),
    .mode_data_i   (mode_data),
    .pin_sync_i    (pin_sync),
    .frame_start_i (frame_start),
    .bclk_first_i  (bclk_first),
    .rd_win_i      (rd_win),
    .status_o      (status_o)
  );

  // Cycles since reset, for assertions that look back in time.
  logic [3:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                   age_q <= '0;
    else if (age_q != AGE_MAX) age_q <= age_q + 4'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pin_oe_o == '0 && status_o == RST_STATUS))
    else $error("reset state wrong");

  // R3
  drive_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && mode_data) |=> $stable(pin_oe_o))
    else $error("pin drive changed off the write point");

  // R7
  ctrl_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_CTRL) |=> $stable(pin_oe_o))
    else $error("pin drive changed in control mode");

  // R8
  ctrl_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q == AGE_MAX && bclk_first && !mode_data)
      |=> (status_o[NPINS-1:0] == $past(pin_i, SYNC_STAGES + 1)))
    else $error("control-mode sample does not match synchronised pin");
endmodule

// File: tb/odpio_port_tb_top.sv
module odpio_port_tb_top;
  localparam int NP = 2;
  localparam int RW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, mode, fsync, bclk, wr_en;
  logic [NP-1:0] wr_data, ext_drv, pin_oe, pin_lvl;
  logic [RW-1:0] status;

  // Wired-AND: the pin is low if the block or the outside pulls it low.
  assign pin_lvl = ext_drv & ~pin_oe;

  odpio_port #(.NPINS(NP), .REG_W(RW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode),
    .fsync_i   (fsync),
    .bclk_i    (bclk),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .pin_i     (pin_lvl),
    .pin_oe_o  (pin_oe),
    .status_o  (status)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int            at;
    bit            is_st;
    logic [RW-1:0] exp;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  task automatic push(input int at, input bit is_st, input logic [RW-1:0] exp, input string tag);
    exp_t it;
    int   pos;
    it.at = at; it.is_st = is_st; it.exp = exp; it.tag = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].at > at) begin
        pos = i;
        break;
      end
    end
    q.insert(pos, it);
  endtask

  // Monitor: compares due items mid-cycle, away from the clock edges.
  initial begin
    exp_t          it;
    logic [RW-1:0] act;
    forever begin
      @(posedge clk);
      #3;
      while (q.size() > 0 && q[0].at <= cyc) begin
        it  = q.pop_front();
        act = it.is_st ? status : {{(RW-NP){1'b0}}, pin_oe};
        checks++;
        if (it.at != cyc || act !== it.exp) begin
          fails++;
          $display("FAIL %s cycle=%0d actual=%h expected=%h", it.tag, cyc, act, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic goto(input int c);
    while (cyc < c) tick(1);
  endtask

  task automatic start_frame(output int e0);
    fsync = 1'b1;
    tick(1);
    e0    = cyc;
    fsync = 1'b0;
  endtask

  task automatic wr(input logic [NP-1:0] v);
    wr_data = v;
    wr_en   = 1'b1;
    tick(1);
    wr_en   = 1'b0;
  endtask

  initial begin
    int e, e1, e2;
    rst = 1'b1; mode = 1'b1; fsync = 1'b0; bclk = 1'b0;
    wr_en = 1'b0; wr_data = '0; ext_drv = 2'b11;
    tick(4);
    push(cyc, 1'b0, 8'h00, "R1 drive after reset");
    push(cyc, 1'b1, 8'h03, "R1 R9 status after reset");
    rst = 1'b0;
    tick(2);
    start_frame(e);
    goto(e + 14);

    // Data-mode write: drive pin 0 low (latch 2'b10).
    wr(2'b10);
    start_frame(e);
    push(e + 10, 1'b0, 8'h00, "R3 drive held before write point");
    push(e + 11, 1'b0, 8'h01, "R3 R2 write applied, pin0 pulled low");
    goto(e + 14);

    // Two writes inside the frame; the last one wins.
    start_frame(e);
    goto(e + 3); wr(2'b00);
    goto(e + 5); wr(2'b11);
    push(e + 10, 1'b0, 8'h01, "R3 drive held before write point");
    push(e + 11, 1'b0, 8'h00, "R3 last write wins, both released");
    goto(e + 14);

    // Half-cycle read point and next-frame report.
    ext_drv = 2'b00;
    tick(3);
    start_frame(e);
    goto(e + 6); ext_drv = 2'b01;   // reaches sync output before the read point
    goto(e + 7); ext_drv = 2'b11;   // reaches it just after the read point
    push(e + 12, 1'b1, 8'h02, "R5 previous frame value still shown");
    push(e + 20, 1'b1, 8'h02, "R5 no report before next frame");
    push(e + 21, 1'b1, 8'h01, "R4 R8 captured at 8.5 periods");
    goto(e + 20);
    start_frame(e1);
    push(e1 + 19, 1'b1, 8'h01, "R5 status held through frame");
    goto(e1 + 19);
    start_frame(e2);
    push(e2, 1'b1, 8'h03, "R4 R9 steady level reported");
    goto(e2 + 14);

    // Control mode ignores writes; pending value kept.
    mode = 1'b0;
    wr(2'b00);
    start_frame(e);
    push(e + 12, 1'b0, 8'h00, "R7 control-mode write ignored");
    goto(e + 14);
    mode = 1'b1;
    start_frame(e);
    push(e + 12, 1'b0, 8'h00, "R7 pending value untouched");
    goto(e + 14);

    // Control-mode reads on the first bit-clock rise.
    mode = 1'b0;
    ext_drv = 2'b01;
    tick(3);
    start_frame(e);
    goto(e + 3); bclk = 1'b1;
    push(e + 4, 1'b1, 8'h01, "R6 sampled on bit clock");
    goto(e + 6); bclk = 1'b0;
    ext_drv = 2'b10;
    tick(3);
    start_frame(e);
    goto(e + 3);
    push(e + 3, 1'b1, 8'h01, "R6 unchanged before bit clock");
    bclk = 1'b1;
    push(e + 4, 1'b1, 8'h02, "R6 same-frame report");
    goto(e + 6); bclk = 1'b0; ext_drv = 2'b01;
    goto(e + 10); bclk = 1'b1;
    push(e + 13, 1'b1, 8'h02, "R6 later bit clock ignored");
    goto(e + 12); bclk = 1'b0;
    goto(e + 15);
    start_frame(e);
    goto(e + 2); bclk = 1'b1;
    push(e + 3, 1'b1, 8'h01, "R6 next frame sample");
    goto(e + 5); bclk = 1'b0;

    while (q.size() > 0) tick(1);
    tick(2);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule